// File: doc/BRIEF.md
# Ping-Pong Gamma Lookup Table

This block applies a per-channel gamma table to a pixel stream. It holds two complete table banks, A and B, each with a red, a green and a blue table. While the pixel path reads one bank, a host register port fills the other. The host chooses the bank to fill, chooses which colour channels a data write lands in through a 3-bit mask, and streams values through a data register whose entry index advances by itself after every write.

The host programs a pending mode and a pending bank select. These are copied into the current mode and bank only on a frame-start pulse, so a frame is never processed with a mix of two tables. The current values can be read back. In table mode, each 10-bit input channel keeps only its upper 9 bits, which directly index the table. The stored value comes out one cycle later. In any other mode the pixel passes through unchanged with the same latency. A power-disable bit forces the table memory on, and a status bit reads 0 whenever the memory is powered.

Top module: `gamma_pingpong_lut`

## Requirements
- R1: After reset, the pending and current mode and bank select are 0. The write index is 0, the write mask is 7, the host bank is 0, and the power-disable bit is 0. The power status reads 1. Register map (addresses on host_addr):
  - 0, control: [1:0] pending mode, [4] pending select, read-only [9:8] current mode, [12] current select.
  - 1, table config: [2:0] write mask, [4] host bank.
  - 2, index: [9:0].
  - 3, data: [9:0], write only.
  - 4, power: [0] power-disable, read-only [8] power status.
- R2: When the current mode is any value other than 2, each output channel equals its input channel one cycle later.
- R3: When the current mode is 2, each output channel equals the entry of the current bank's table for that channel at index input[9:1], one cycle later.
- R4: A data write updates the red table when mask bit 2 is set, green when bit 1 is set, and blue when bit 0 is set. A mask of 7 updates all three, and a mask of 0 updates none.
- R5: Host bank 0 routes data writes to bank A and 1 to bank B. Current select 0 makes the pixel path read bank A and 1 bank B.
- R6: Each data write stores at the current index and then advances it. After entry 512 the index returns to 0, so a full load is 512 entries plus one terminating entry. Writing an index above 512 sets it to 0.
- R7: Current mode and select change only on a frame-start pulse, which copies the pending values into them.
- R8: A pixel presented in the same cycle as the frame-start pulse is already processed with the newly copied mode and select.
- R9: The power status reads 0 one cycle after the power-disable bit is 1, or after the pending or current mode is 2. Otherwise it reads 1.
- R10: Data writes to the bank the pixel path is currently reading are still accepted and show up in the output immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered readback of the register at host_addr |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| pix_in_r | input | 10 | Red input channel |
| pix_in_g | input | 10 | Green input channel |
| pix_in_b | input | 10 | Blue input channel |
| pix_out_r | output | 10 | Red output channel |
| pix_out_g | output | 10 | Green output channel |
| pix_out_b | output | 10 | Blue output channel |

## Verification
The assertions assume that the host writes at most one register per cycle. Under that assumption, a data write never coincides with an index write, so the index changes only by the increment-or-wrap rule.

The pass-through property assumes the current mode is steady. For that reason it applies only in cycles without a frame-start pulse.

The directed stimulus keeps to these limits:
- It issues host writes with an idle cycle between them.
- It never reads a table entry in the same cycle that entry is written.
- It fills both banks completely before table mode is first selected, so no lookup returns an unwritten entry.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_LUTCFG = 3'd1,
    RA_INDEX  = 3'd2,
    RA_DATA   = 3'd3,
    RA_PWR    = 3'd4
  } reg_addr_e;

  localparam logic [1:0] MODE_BYPASS = 2'd0;
  localparam logic [1:0] MODE_TABLE  = 2'd2;
  localparam int         NUM_CH      = 3;
  localparam int         NUM_BANKS   = 2;
endpackage

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 513,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps to one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/gamma_lut_regs.sv
module gamma_lut_regs
  import gamma_lut_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int DATA_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [2:0]       host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             frame_start,
  output logic [1:0]       mode_pend,
  output logic             sel_pend,
  output logic [1:0]       mode_cur,
  output logic             sel_cur,
  output logic [2:0]       wr_mask,
  output logic             wr_bank,
  output logic [IDX_W:0]   idx,
  output logic             data_we,
  output logic [DATA_W-1:0] data_val,
  output logic             pwr_dis,
  output logic             pwr_state
);
  localparam logic [IDX_W:0] LAST_IDX = (IDX_W+1)'(1 << IDX_W);

  logic [31:0] rd_mux;

  assign data_we  = host_we && (host_addr == RA_DATA);
  assign data_val = host_wdata[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_pend <= MODE_BYPASS;
      sel_pend  <= 1'b0;
      wr_mask   <= 3'b111;
      wr_bank   <= 1'b0;
      idx       <= '0;
      pwr_dis   <= 1'b0;
    end else begin
      if (host_we) begin
        case (host_addr)
          RA_CTRL: begin
            mode_pend <= host_wdata[1:0];
            sel_pend  <= host_wdata[4];
          end
          RA_LUTCFG: begin
            wr_mask <= host_wdata[2:0];
            wr_bank <= host_wdata[4];
          end
          RA_INDEX:
            idx <= (host_wdata[IDX_W:0] <= LAST_IDX && host_wdata[31:IDX_W+1] == '0)
                   ? host_wdata[IDX_W:0] : '0;
          RA_DATA:
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
          RA_PWR:
            pwr_dis <= host_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // pending -> current only at frame boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_cur <= MODE_BYPASS;
      sel_cur  <= 1'b0;
    end else if (frame_start) begin
      mode_cur <= mode_pend;
      sel_cur  <= sel_pend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwr_state <= 1'b1;
    else     pwr_state <= !(pwr_dis || mode_pend == MODE_TABLE || mode_cur == MODE_TABLE);
  end

  always_comb begin
    rd_mux = '0;
    case (host_addr)
      RA_CTRL: begin
        rd_mux[1:0] = mode_pend;
        rd_mux[4]   = sel_pend;
        rd_mux[9:8] = mode_cur;
        rd_mux[12]  = sel_cur;
      end
      RA_LUTCFG: begin
        rd_mux[2:0] = wr_mask;
        rd_mux[4]   = wr_bank;
      end
      RA_INDEX: rd_mux[IDX_W:0] = idx;
      RA_PWR: begin
        rd_mux[0] = pwr_dis;
        rd_mux[8] = pwr_state;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_mux;
  end
endmodule

// File: rtl/gamma_pingpong_lut.sv
module gamma_pingpong_lut
  import gamma_lut_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int PIX_W  = 10,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              frame_start,
  input  logic [PIX_W-1:0]  pix_in_r,
  input  logic [PIX_W-1:0]  pix_in_g,
  input  logic [PIX_W-1:0]  pix_in_b,
  output logic [DATA_W-1:0] pix_out_r,
  output logic [DATA_W-1:0] pix_out_g,
  output logic [DATA_W-1:0] pix_out_b
);
  localparam int DEPTH  = (1 << IDX_W) + 1;
  localparam int ADDR_W = IDX_W + 1;

  logic [1:0]        mode_pend, mode_cur;
  logic              sel_pend, sel_cur;
  logic [2:0]        wr_mask;
  logic              wr_bank;
  logic [IDX_W:0]    idx;
  logic              data_we;
  logic [DATA_W-1:0] data_val;
  logic              pwr_dis, pwr_state;

  gamma_lut_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .frame_start(frame_start),
    .mode_pend(mode_pend), .sel_pend(sel_pend),
    .mode_cur(mode_cur), .sel_cur(sel_cur),
    .wr_mask(wr_mask), .wr_bank(wr_bank), .idx(idx),
    .data_we(data_we), .data_val(data_val),
    .pwr_dis(pwr_dis), .pwr_state(pwr_state)
  );

  // a pixel arriving with frame_start already belongs to the new frame
  logic [1:0] eff_mode;
  logic       eff_bank;
  logic       use_tbl_q, bank_q;

  assign eff_mode = frame_start ? mode_pend : mode_cur;
  assign eff_bank = frame_start ? sel_pend  : sel_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      use_tbl_q <= 1'b0;
      bank_q    <= 1'b0;
    end else begin
      use_tbl_q <= (eff_mode == MODE_TABLE);
      bank_q    <= eff_bank;
    end
  end

  // channel index c: 2 = red, 1 = green, 0 = blue (matches mask bit)
  logic [PIX_W-1:0]  pin  [NUM_CH];
  logic [DATA_W-1:0] pout [NUM_CH];

  assign pin[2] = pix_in_r;
  assign pin[1] = pix_in_g;
  assign pin[0] = pix_in_b;
  assign pix_out_r = pout[2];
  assign pix_out_g = pout[1];
  assign pix_out_b = pout[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] rd_bk [NUM_BANKS];
    logic [PIX_W-1:0]  pix_q;
    logic [ADDR_W-1:0] raddr;

    assign raddr = {1'b0, pin[c][PIX_W-1 -: IDX_W]};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      gamma_lut_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk),
        .we(data_we && wr_mask[c] && (wr_bank == 1'(b))),
        .waddr(idx),
        .wdata(data_val),
        .raddr(raddr),
        .rdata(rd_bk[b])
      );
    end

    always_ff @(posedge clk) begin
      if (rst) pix_q <= '0;
      else     pix_q <= pin[c];
    end

    assign pout[c] = use_tbl_q ? (bank_q ? rd_bk[1] : rd_bk[0]) : DATA_W'(pix_q);
  end
endmodule

// File: rtl/gamma_lut_checker.sv
module gamma_lut_checker #(
  parameter int IDX_W = 9,
  parameter int PIX_W = 10,
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start,
  input logic              data_we,
  input logic [1:0]        mode_pend,
  input logic              sel_pend,
  input logic [1:0]        mode_cur,
  input logic              sel_cur,
  input logic [IDX_W:0]    idx,
  input logic              pwr_dis,
  input logic              pwr_state,
  input logic [PIX_W-1:0]  pix_in_r,
  input logic [DATA_W-1:0] pix_out_r
);
  localparam logic [IDX_W:0] LAST_IDX = (IDX_W+1)'(1 << IDX_W);

  assert_cur_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(mode_cur) && $stable(sel_cur));

  assert_cur_latch_R7: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> mode_cur == $past(mode_pend) && sel_cur == $past(sel_pend));

  assert_idx_step_R6: assert property (@(posedge clk) disable iff (rst)
    (data_we && idx != LAST_IDX) |=> idx == $past(idx) + 1'b1);

  assert_idx_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (data_we && idx == LAST_IDX) |=> idx == '0);

  assert_bypass_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && mode_cur != 2'd2) |=> pix_out_r == DATA_W'($past(pix_in_r)));

  assert_pwr_forced_R9: assert property (@(posedge clk) disable iff (rst)
    pwr_dis |=> !pwr_state);
endmodule

bind gamma_pingpong_lut gamma_lut_checker #(.IDX_W(IDX_W), .PIX_W(PIX_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .data_we(data_we),
  .mode_pend(mode_pend), .sel_pend(sel_pend), .mode_cur(mode_cur), .sel_cur(sel_cur),
  .idx(idx), .pwr_dis(pwr_dis), .pwr_state(pwr_state),
  .pix_in_r(pix_in_r), .pix_out_r(pix_out_r)
);

// File: tb/gamma_pingpong_lut_bench.sv
`timescale 1ns/1ps
module gamma_pingpong_lut_bench;
  localparam int IDX_W = 9;
  localparam int PIX_W = 10;
  localparam int DATA_W = 10;
  localparam int NENT = 513;

  localparam logic [2:0] A_CTRL = 3'd0, A_CFG = 3'd1, A_IDX = 3'd2, A_DATA = 3'd3, A_PWR = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic frame_start = 1'b0;
  logic [PIX_W-1:0] pin_r = '0, pin_g = '0, pin_b = '0;
  logic [DATA_W-1:0] pout_r, pout_g, pout_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model: [bank][channel 2=r 1=g 0=b][entry]
  logic [DATA_W-1:0] expt [2][3][NENT];

  always #4 clk = ~clk;

  gamma_pingpong_lut #(.IDX_W(IDX_W), .PIX_W(PIX_W), .DATA_W(DATA_W)) u_gamma_pingpong_lut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .frame_start(frame_start),
    .pix_in_r(pin_r), .pix_in_g(pin_g), .pix_in_b(pin_b),
    .pix_out_r(pout_r), .pix_out_g(pout_g), .pix_out_b(pout_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [DATA_W-1:0] pat(input int b, input int c, input int i);
    return DATA_W'((i * 7 + c * 181 + b * 401 + 3) & 1023);
  endfunction

  task automatic hw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic pix(input logic [9:0] r, input logic [9:0] g, input logic [9:0] b, input logic fs);
    @(negedge clk);
    pin_r = r; pin_g = g; pin_b = b; frame_start = fs;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic chk_tbl(input string req, input int bank, input logic [9:0] r,
                         input logic [9:0] g, input logic [9:0] b);
    check(req, 32'(pout_r), 32'(expt[bank][2][r >> 1]));
    check(req, 32'(pout_g), 32'(expt[bank][1][g >> 1]));
    check(req, 32'(pout_b), 32'(expt[bank][0][b >> 1]));
  endtask

  task automatic chk_byp(input string req, input logic [9:0] r, input logic [9:0] g, input logic [9:0] b);
    check(req, 32'(pout_r), 32'(r));
    check(req, 32'(pout_g), 32'(g));
    check(req, 32'(pout_b), 32'(b));
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    hr(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    hr(A_CFG, d);  check("R1 cfg", d, 32'h7);
    hr(A_IDX, d);  check("R1 index", d, 32'h0);
    hr(A_PWR, d);  check("R1 pwr", d, 32'h100);
  endtask

  task automatic t_bypass();
    pix(10'd5, 10'd700, 10'd1023, 1'b0); chk_byp("R2 bypass", 10'd5, 10'd700, 10'd1023);
    pix(10'd0, 10'd1, 10'd512, 1'b0);    chk_byp("R2 bypass", 10'd0, 10'd1, 10'd512);
  endtask

  // per-channel fills exercise masks R4, bank routing R5, index run and wrap R6
  task automatic t_load(input int b);
    logic [31:0] d;
    for (int c = 0; c < 3; c++) begin
      hw(A_CFG, (32'(b) << 4) | (32'd1 << c));
      hw(A_IDX, 32'd0);
      for (int i = 0; i < NENT; i++) begin
        hw(A_DATA, 32'(pat(b, c, i)));
        expt[b][c][i] = pat(b, c, i);
      end
      hr(A_IDX, d); check("R6 index wraps after entry 512", d, 32'h0);
    end
  endtask

  task automatic t_frame_switch();
    logic [31:0] d;
    hw(A_CTRL, 32'h2);
    hr(A_CTRL, d); check("R7 pending only", d, 32'h002);
    pix(10'd100, 10'd300, 10'd1023, 1'b0); chk_byp("R7 no switch before frame", 10'd100, 10'd300, 10'd1023);
    pix(10'd100, 10'd300, 10'd1023, 1'b1); chk_tbl("R8 frame-start pixel uses new mode", 0, 10'd100, 10'd300, 10'd1023);
    hr(A_CTRL, d); check("R7 current after frame", d, 32'h202);
    hr(A_PWR, d);  check("R9 powered in table mode", d, 32'h0);
  endtask

  task automatic t_lookup();
    pix(10'd0, 10'd1, 10'd2, 1'b0);       chk_tbl("R3 lookup low", 0, 10'd0, 10'd1, 10'd2);
    pix(10'd1023, 10'd511, 10'd77, 1'b0); chk_tbl("R3 lookup high", 0, 10'd1023, 10'd511, 10'd77);
  endtask

  task automatic t_bank_swap();
    logic [31:0] d;
    hw(A_CTRL, 32'h12);
    pix(10'd40, 10'd41, 10'd900, 1'b0); chk_tbl("R7 old bank kept mid-frame", 0, 10'd40, 10'd41, 10'd900);
    pix(10'd40, 10'd41, 10'd900, 1'b1); chk_tbl("R5 bank B after frame", 1, 10'd40, 10'd41, 10'd900);
    hr(A_CTRL, d); check("R7 select current", d, 32'h1212);
  endtask

  task automatic t_mask_all();
    logic [31:0] d;
    hw(A_CFG, 32'h07);
    hw(A_IDX, 32'd10);
    hw(A_DATA, 32'h2AA);
    for (int c = 0; c < 3; c++) expt[0][c][10] = 10'h2AA;
    hr(A_IDX, d); check("R6 index advanced", d, 32'd11);
    hw(A_CFG, 32'h00);
    hw(A_DATA, 32'h3FF);  // mask 0: entry 11 untouched
    hr(A_IDX, d); check("R6 index advanced on masked write", d, 32'd12);
    hw(A_CTRL, 32'h02);
    pix(10'd20, 10'd21, 10'd22, 1'b1); chk_tbl("R4 mask 7 and mask 0", 0, 10'd20, 10'd21, 10'd22);
  endtask

  task automatic t_index_range();
    logic [31:0] d;
    hw(A_IDX, 32'd600);
    hr(A_IDX, d); check("R6 out-of-range index", d, 32'd0);
    hw(A_CFG, 32'h07);
    hw(A_IDX, 32'd512);
    hr(A_IDX, d); check("R6 top index accepted", d, 32'd512);
    hw(A_DATA, 32'h155);
    for (int c = 0; c < 3; c++) expt[0][c][512] = 10'h155;
    hr(A_IDX, d); check("R6 wrap from 512", d, 32'd0);
  endtask

  task automatic t_active_write();
    hw(A_CFG, 32'h04);
    hw(A_IDX, 32'd3);
    hw(A_DATA, 32'h111);
    expt[0][2][3] = 10'h111;
    pix(10'd6, 10'd7, 10'd0, 1'b0); chk_tbl("R10 write to active bank", 0, 10'd6, 10'd7, 10'd0);
  endtask

  task automatic t_power();
    logic [31:0] d;
    hw(A_CTRL, 32'h0);
    pix(10'd7, 10'd8, 10'd9, 1'b1); chk_byp("R2 back to bypass", 10'd7, 10'd8, 10'd9);
    hr(A_PWR, d); check("R9 unpowered in bypass", d, 32'h100);
    hw(A_PWR, 32'h1);
    hr(A_PWR, d); check("R9 forced on", d, 32'h001);
    hw(A_PWR, 32'h0);
    hr(A_PWR, d); check("R9 release", d, 32'h100);
  endtask

  task automatic t_mode_other();
    logic [31:0] d;
    hw(A_CTRL, 32'h1);
    pix(10'd33, 10'd600, 10'd999, 1'b1); chk_byp("R2 mode 1 passes through", 10'd33, 10'd600, 10'd999);
    hr(A_CTRL, d); check("R2 mode 1 current", d, 32'h101);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_bypass();
    t_load(0);
    t_load(1);
    t_frame_switch();
    t_lookup();
    t_bank_swap();
    t_mask_all();
    t_index_range();
    t_active_write();
    t_power();
    t_mode_other();
    done = 1'b1;
    report();
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end
endmodule